// File: doc/BRIEF.md
# Saturating Cache Event Counter Unit

This block counts cache activity for performance analysis. It holds two identical 32-bit counters. Each counter listens to one of fifteen single-bit event pulse inputs, and a per-counter configuration register chooses which one. A counter advances by at most one per clock. It stops at all-ones and never wraps to zero.

Software reaches the unit through a plain register bus made of an address, a write strobe, write data and combinational read data. Through this bus it sets a global run bit, clears individual counters, loads counter values and manages one shared interrupt. Each counter has its own interrupt mode: off, on every increment, or on reaching saturation. The triggers from both counters merge into one sticky raw status bit. A mask bit gates that status onto the interrupt output.

A separate monitor-enable input stands for the cache controller's event monitor switch. Nothing counts while that input is low.

Top module: `cache_evt_mon`

## Requirements
- R1: After reset, every mapped register reads zero and `irq_out` is low.
- R2: Counter n increments by one in each cycle where all of these hold: the run bit (control bit 0) is 1, `mon_on` is high, the counter's source code (configuration bits [5:2]) is a nonzero value k, and `evt_in[k-1]` is high.
- R3: A counter does not change when any one of these holds: the run bit is 0, `mon_on` is low, its source code is 0, or only event inputs other than the selected one pulse.
- R4: A counter at 0xFFFFFFFF stays at 0xFFFFFFFF while further selected events arrive.
- R5: A write to a counter's value register loads the write data only while that counter's source code is 0. Otherwise the write is ignored.
- R6: Writing control with bit (n+1) set clears counter n and leaves the other counter alone. Control bit 0 reads back as written, and the clear bits read as 0.
- R7: Interrupt mode 1 (configuration bits [1:0] = 1) sets the raw status on every increment. `irq_out` equals the raw status ANDed with mask bit 0.
- R8: Interrupt mode 2 sets the raw status only on the increment that brings the counter to 0xFFFFFFFF. Mode 0 never sets it.
- R9: The raw status stays set until a write with bit 0 set to the clear register. If a new trigger arrives in the same cycle as the clear, the status stays set.
- R10: Reads of the clear register and of any unmapped address return zero, and writes to unmapped addresses change nothing.
- R11: Byte address map: control 0x00, mask 0x04, raw status 0x08 (read only), clear 0x0C (write only), configuration of counter 0 at 0x34 and of counter 1 at 0x30, value of counter 0 at 0x24 and of counter 1 at 0x20. A configuration register keeps only bits [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_on | input | 1 | Event monitor switch; counting needs it high |
| evt_in | input | 15 | Event pulses; bit k-1 is selected by source code k |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Masked event-counter interrupt |

## Verification
The assertions assume that each bus write lasts exactly one clock and that event inputs are clean levels sampled on the rising edge. They also assume that a counter changes only through a clear, an accepted load or a single increment. The stimulus therefore changes the bus signals and event inputs only on falling edges and holds each write strobe for one cycle. It changes a source code only between event bursts. The same-cycle trigger-and-clear case is produced on purpose by raising an event in the same cycle as a clear write.

// File: rtl/cem_pkg.sv
package cem_pkg;

  typedef enum logic [1:0] {
    IRQ_OFF  = 2'd0,
    IRQ_EACH = 2'd1,
    IRQ_SAT  = 2'd2,
    IRQ_RSV  = 2'd3
  } irq_mode_e;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_MASK = 'h04;
  localparam int OFF_RAW  = 'h08;
  localparam int OFF_CLR  = 'h0C;
  localparam int OFF_VAL0 = 'h24;
  localparam int OFF_CFG0 = 'h34;
  localparam int STRIDE   = 4;

  // counter n sits one word below counter n-1
  function automatic int cfg_off(input int idx);
    return OFF_CFG0 - STRIDE * idx;
  endfunction

  function automatic int val_off(input int idx);
    return OFF_VAL0 - STRIDE * idx;
  endfunction

endpackage

// File: rtl/cem_regs.sv
module cem_regs
  import cem_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int DATA_W  = 32,
  parameter int SRC_W   = 4,
  parameter int ADDR_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           we,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_val,
  input  logic                           raw_q,
  output logic [DATA_W-1:0]              rdata,
  output logic                           run_en,
  output logic                           mask_q,
  output logic                           clr_pulse,
  output logic [NUM_CNT-1:0]             cnt_clr,
  output logic [NUM_CNT-1:0]             val_wr,
  output logic [NUM_CNT-1:0][SRC_W-1:0]  cfg_src,
  output logic [NUM_CNT-1:0][1:0]        cfg_mode
);

  localparam int CFG_W = SRC_W + 2;

  logic hit_ctrl, hit_mask, hit_raw, hit_clr;
  logic [NUM_CNT-1:0] hit_cfg, hit_val;

  assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
  assign hit_mask = (addr == ADDR_W'(OFF_MASK));
  assign hit_raw  = (addr == ADDR_W'(OFF_RAW));
  assign hit_clr  = (addr == ADDR_W'(OFF_CLR));

  assign clr_pulse = we & hit_clr & wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      mask_q <= 1'b0;
    end else if (we) begin
      if (hit_ctrl) run_en <= wdata[0];
      if (hit_mask) mask_q <= wdata[0];
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt_regs
    logic [CFG_W-1:0] cfg_q;

    assign hit_cfg[n] = (addr == ADDR_W'(cfg_off(n)));
    assign hit_val[n] = (addr == ADDR_W'(val_off(n)));
    assign val_wr[n]  = we & hit_val[n];
    assign cnt_clr[n] = we & hit_ctrl & wdata[n+1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cfg_q <= '0;
      else if (we && hit_cfg[n]) cfg_q <= wdata[CFG_W-1:0];
    end

    assign cfg_src[n]  = cfg_q[CFG_W-1:2];
    assign cfg_mode[n] = cfg_q[1:0];
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl) rdata[0] = run_en;
    if (hit_mask) rdata[0] = mask_q;
    if (hit_raw)  rdata[0] = raw_q;
    for (int n = 0; n < NUM_CNT; n++) begin
      if (hit_cfg[n]) rdata = DATA_W'({cfg_src[n], cfg_mode[n]});
      if (hit_val[n]) rdata = cnt_val[n];
    end
  end

endmodule

// File: rtl/cem_counter.sv
module cem_counter
  import cem_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 15,
  parameter int SRC_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SRC_W-1:0]   src,
  input  logic [1:0]         mode,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               clr,
  input  logic               wr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               inc_fire,
  output logic               ld_ok,
  output logic               trig
);

  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v);
    return (v == TOP) ? v : v + CNT_W'(1);
  endfunction

  function automatic logic reaches_top(input logic [CNT_W-1:0] v);
    return v == (TOP - CNT_W'(1));
  endfunction

  logic sel_evt;
  logic at_top;
  irq_mode_e mode_e;

  always_comb begin
    sel_evt = 1'b0;
    for (int k = 0; k < NUM_EVT; k++)
      if (int'(src) == k + 1) sel_evt = evt_in[k];
  end

  assign mode_e   = irq_mode_e'(mode);
  assign at_top   = (cnt_q == TOP);
  assign ld_ok    = wr & (src == '0) & ~clr;
  assign inc_fire = run & sel_evt & ~at_top & ~clr & ~ld_ok;

  always_comb begin
    unique case (mode_e)
      IRQ_EACH: trig = inc_fire;
      IRQ_SAT:  trig = inc_fire & reaches_top(cnt_q);
      default:  trig = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (ld_ok)    cnt_q <= wdata;
    else if (inc_fire) cnt_q <= sat_step(cnt_q);
  end

endmodule

// File: rtl/cem_irq.sv
module cem_irq #(
  parameter int NUM_CNT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] trig,
  input  logic               clr_pulse,
  input  logic               mask_q,
  output logic               trig_any,
  output logic               raw_q,
  output logic               irq_out
);

  assign trig_any = |trig;

  // a fresh trigger wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         raw_q <= 1'b0;
    else if (trig_any)  raw_q <= 1'b1;
    else if (clr_pulse) raw_q <= 1'b0;
  end

  assign irq_out = raw_q & mask_q;

endmodule

// File: rtl/cache_evt_mon.sv
module cache_evt_mon
  import cem_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 15,
  parameter int SRC_W   = 4,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mon_on,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  output logic               irq_out
);

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CNT-1:0][SRC_W-1:0] cfg_src;
  logic [NUM_CNT-1:0][1:0]       cfg_mode;
  logic [NUM_CNT-1:0]            cnt_clr, val_wr, cnt_ld, cnt_inc, cnt_trig, src_nz;
  logic run_en, mask_q, clr_pulse, raw_q, trig_any, cnt_run;

  assign cnt_run = run_en & mon_on;

  cem_regs #(
    .NUM_CNT(NUM_CNT), .DATA_W(CNT_W), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .cnt_val(cnt_q), .raw_q(raw_q), .rdata(bus_rdata), .run_en(run_en),
    .mask_q(mask_q), .clr_pulse(clr_pulse), .cnt_clr(cnt_clr), .val_wr(val_wr),
    .cfg_src(cfg_src), .cfg_mode(cfg_mode)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    assign src_nz[n] = |cfg_src[n];
    cem_counter #(
      .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .SRC_W(SRC_W)
    ) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(cnt_run), .src(cfg_src[n]),
      .mode(cfg_mode[n]), .evt_in(evt_in), .clr(cnt_clr[n]), .wr(val_wr[n]),
      .wdata(bus_wdata), .cnt_q(cnt_q[n]), .inc_fire(cnt_inc[n]),
      .ld_ok(cnt_ld[n]), .trig(cnt_trig[n])
    );
  end

  cem_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk(clk), .rst_n(rst_n), .trig(cnt_trig), .clr_pulse(clr_pulse),
    .mask_q(mask_q), .trig_any(trig_any), .raw_q(raw_q), .irq_out(irq_out)
  );

endmodule

// File: rtl/cem_chk.sv
module cem_chk #(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
  input logic                          run,
  input logic [NUM_CNT-1:0]            clr,
  input logic [NUM_CNT-1:0]            ld,
  input logic [NUM_CNT-1:0]            val_wr,
  input logic [NUM_CNT-1:0]            src_nz,
  input logic                          trig_any,
  input logic                          clr_pulse,
  input logic                          raw_q,
  input logic                          irq_out
);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[g] && !ld[g]) |=> (cnt_q[g] == $past(cnt_q[g]) ||
                               cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1)));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr[g] && !ld[g]) |=> $stable(cnt_q[g]));
    // R4
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] == '1 && !clr[g] && !ld[g]) |=> cnt_q[g] == '1);
    // R5
    locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (val_wr[g] && src_nz[g] && !clr[g]) |=>
        (cnt_q[g] == $past(cnt_q[g]) || cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1)));
    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr[g] |=> cnt_q[g] == '0);
  end

  // R9
  raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_any |=> raw_q);
  // R9
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !trig_any) |=> !raw_q);
  // R9
  raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clr_pulse) |=> raw_q);
  // R7
  irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> raw_q);

endmodule

bind cache_evt_mon cem_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .run(cnt_run), .clr(cnt_clr),
  .ld(cnt_ld), .val_wr(val_wr), .src_nz(src_nz), .trig_any(trig_any),
  .clr_pulse(clr_pulse), .raw_q(raw_q), .irq_out(irq_out)
);

// File: tb/tb_cache_evt_mon.sv
module tb_cache_evt_mon;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_MASK = 8'h04, A_RAW = 8'h08,
                         A_CLR = 8'h0C, A_VAL0 = 8'h24, A_VAL1 = 8'h20,
                         A_CFG0 = 8'h34, A_CFG1 = 8'h30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mon_on = 1'b0;
  logic [14:0] evt_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_evt_mon dut (
    .clk(clk), .rst_n(rst_n), .mon_on(mon_on), .evt_in(evt_in),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [14:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt_in = m;
    end
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", A_CTRL, 0);
    rd_chk("R1 mask", A_MASK, 0);
    rd_chk("R1 raw", A_RAW, 0);
    rd_chk("R1 cfg0", A_CFG0, 0);
    rd_chk("R1 cfg1", A_CFG1, 0);
    rd_chk("R1 val0", A_VAL0, 0);
    rd_chk("R1 val1", A_VAL1, 0);
    check("R1 irq", {31'd0, irq_out}, 0);
  endtask

  task automatic t_unmapped;
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped 0x40", 8'h40, 0);
    rd_chk("R10 unmapped 0x10", 8'h10, 0);
    wr(A_CLR, 32'h1);
    rd_chk("R10 clear reg reads zero", A_CLR, 0);
    rd_chk("R10 ctrl untouched", A_CTRL, 0);
  endtask

  task automatic t_layout;
    wr(A_CFG0, 32'hFFFF_FFCC);
    wr(A_CFG1, 32'h0000_003C);
    rd_chk("R11 cfg0 keeps [5:0]", A_CFG0, 32'h0C);
    rd_chk("R11 cfg1 at 0x30", A_CFG1, 32'h3C);
    wr(A_CFG0, 0); wr(A_CFG1, 0);
    wr(A_VAL0, 32'h11); wr(A_VAL1, 32'h22);
    rd_chk("R11 val0 at 0x24", A_VAL0, 32'h11);
    rd_chk("R11 val1 at 0x20", A_VAL1, 32'h22);
    wr(A_CTRL, 32'h6);
    rd_chk("R6 clear both val0", A_VAL0, 0);
    rd_chk("R6 clear both val1", A_VAL1, 0);
    rd_chk("R6 ctrl clear bits read 0", A_CTRL, 0);
  endtask

  task automatic t_count;
    mon_on = 1'b1;
    wr(A_CFG0, 32'h0C);
    wr(A_CFG1, 32'h3C);
    wr(A_CTRL, 32'h1);
    pulse(15'h0004, 5);
    pulse(15'h4000, 3);
    pulse(15'h4004, 2);
    rd_chk("R2 cnt0 src3", A_VAL0, 7);
    rd_chk("R2 cnt1 src15", A_VAL1, 5);
    rd_chk("R6 ctrl run bit reads back", A_CTRL, 1);
  endtask

  task automatic t_gate;
    wr(A_CTRL, 0);
    pulse(15'h4004, 4);
    rd_chk("R3 run off cnt0", A_VAL0, 7);
    rd_chk("R3 run off cnt1", A_VAL1, 5);
    wr(A_CTRL, 1);
    mon_on = 1'b0;
    pulse(15'h4004, 4);
    rd_chk("R3 monitor off cnt0", A_VAL0, 7);
    mon_on = 1'b1;
    pulse(15'h0001, 4);
    rd_chk("R3 other event cnt0", A_VAL0, 7);
    wr(A_CFG0, 0);
    pulse(15'h0004, 4);
    rd_chk("R3 src zero cnt0", A_VAL0, 7);
  endtask

  task automatic t_locked;
    wr(A_VAL1, 32'h99);
    rd_chk("R5 write ignored while src set", A_VAL1, 5);
    wr(A_VAL0, 32'h99);
    rd_chk("R5 write taken while src zero", A_VAL0, 32'h99);
    wr(A_CTRL, 32'h5);
    rd_chk("R6 clear cnt1 only", A_VAL1, 0);
    rd_chk("R6 cnt0 kept", A_VAL0, 32'h99);
  endtask

  task automatic t_sat;
    wr(A_VAL0, 32'hFFFF_FFFD);
    wr(A_CFG0, 32'h04);
    pulse(15'h0001, 6);
    rd_chk("R4 saturates", A_VAL0, 32'hFFFF_FFFF);
    pulse(15'h0001, 3);
    rd_chk("R4 stays saturated", A_VAL0, 32'hFFFF_FFFF);
    rd_chk("R8 mode0 no status", A_RAW, 0);
  endtask

  task automatic t_irq_each;
    wr(A_CFG0, 0);
    wr(A_CFG1, 32'h09);
    rd_chk("R7 no event no status", A_RAW, 0);
    pulse(15'h0002, 1);
    rd_chk("R7 status on increment", A_RAW, 1);
    rd_chk("R7 cnt1 advanced", A_VAL1, 1);
    check("R7 masked irq low", {31'd0, irq_out}, 0);
    wr(A_MASK, 1);
    check("R7 unmasked irq high", {31'd0, irq_out}, 1);
    repeat (3) @(negedge clk);
    check("R9 status held", {31'd0, irq_out}, 1);
    wr(A_CLR, 1);
    rd_chk("R9 clear drops status", A_RAW, 0);
    check("R9 irq low after clear", {31'd0, irq_out}, 0);
  endtask

  task automatic t_irq_sat;
    wr(A_CFG1, 0);
    wr(A_VAL0, 32'hFFFF_FFFC);
    wr(A_CFG0, 32'h06);
    pulse(15'h0001, 1);
    rd_chk("R8 below top value", A_VAL0, 32'hFFFF_FFFD);
    rd_chk("R8 no status below top", A_RAW, 0);
    pulse(15'h0001, 2);
    rd_chk("R8 status at top", A_RAW, 1);
    check("R8 irq at top", {31'd0, irq_out}, 1);
    wr(A_CLR, 1);
    pulse(15'h0001, 2);
    rd_chk("R8 no status once stuck", A_RAW, 0);
  endtask

  task automatic t_set_wins;
    wr(A_CFG0, 0);
    wr(A_CFG1, 32'h09);
    @(negedge clk);
    evt_in = 15'h0002; bus_addr = A_CLR; bus_we = 1'b1; bus_wdata = 1;
    @(negedge clk);
    evt_in = '0; bus_we = 1'b0;
    rd_chk("R9 trigger beats clear", A_RAW, 1);
    wr(A_CLR, 1);
    rd_chk("R9 clear alone", A_RAW, 0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unmapped();
    t_layout();
    t_count();
    t_gate();
    t_locked();
    t_sat();
    t_irq_each();
    t_irq_sat();
    t_set_wins();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule